// File: doc/BRIEF.md
# Memory Remap Window Decoder

This block keeps a programmable lower bound and upper bound for one remap window in a 36-bit physical address space and tells, for every presented address, whether that address lands inside the window. Both bounds are held at a 64MB grain. Only address bits 35:26 of each bound are stored. The lower bound is widened with zeros below bit 26. The upper bound is widened with ones below bit 26, so the window always ends one byte short of a 64MB boundary and includes that last byte.

Software loads either bound through a small word-wide write port and can read both back. The undefined upper bits of each 16-bit word are dropped on write and read back as zero. On the decode side, an address qualified by a valid strobe is compared against both widened bounds. One clock later the block returns a hit flag and the byte offset of the address from the window's lower edge. If the programmed upper bound is numerically below the lower bound, the window is switched off and nothing hits.

Top module: `remap_window_dec`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both registers read 0000h, and hit and offset are 0.
- R2: When wr_en is high at a clock edge, wr_sel=0 writes the lower-bound register and wr_sel=1 writes the upper-bound register. Only wr_data[9:0] is kept, and it holds address bits 35:26.
- R3: rd_data returns the register picked by rd_sel (0 = lower bound, 1 = upper bound). Bits 15:10 always read as zero, whatever was written.
- R4: The upper edge is inclusive. The address {limit, 26 ones} hits and the next address up misses.
- R5: The lower edge is inclusive. The address {base, 26 zeros} hits and the address one below it misses.
- R6: When limit is less than base, no address hits. When limit equals base, exactly the 64MB block {base, xxx} hits.
- R7: hit is registered. It shows the decode of the address presented with addr_vld high in the previous cycle, and it is 0 for a cycle in which addr_vld was low.
- R8: offset is registered together with hit. It equals addr minus {base, 26 zeros} when hit is 1, and 0 otherwise.
- R9: A write with wr_en low changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 lower bound, 1 upper bound |
| wr_data | input | 16 | Write word; bits 9:0 are address bits 35:26 |
| rd_sel | input | 1 | Read select: 0 lower bound, 1 upper bound |
| rd_data | output | 16 | Selected register, bits 15:10 zero |
| addr_vld | input | 1 | Address qualifier |
| addr | input | 36 | Physical address to decode |
| hit | output | 1 | Registered window hit |
| offset | output | 36 | Registered offset from window base, 0 on miss |

## Verification
Directed probes sit exactly on the lower and upper edges and one byte outside each. They distinguish an inclusive compare from an exclusive one and catch a wrong fill pattern below bit 26. Windows with limit equal to base and limit below base separate the disabled state from a single-block window. Random bounds with addresses drawn near the window, mixed with idle cycles, compare hit and offset against a bench model and tell a stale or unqualified decode from a correct one. Writes with garbage in the upper bits, and strobes left low, show which bits the registers keep.

// File: rtl/remap_pkg.sv
// Package: shared selector encoding for the remap window decoder.
// Assumes a single remap window with two bound registers.
package remap_pkg;
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } bound_sel_e;
    localparam int NUM_BOUNDS = 2;
endpackage

// File: rtl/remap_bound_reg.sv
// Module: one bound register. It keeps the low FIELD_W bits of a REG_W-bit
// write word and clears the rest, so the reserved bits read back as zero.
// Assumes FIELD_W < REG_W and a synchronous active-low reset.
module remap_bound_reg #(
    parameter int REG_W   = 16,
    parameter int FIELD_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [FIELD_W-1:0] field_q,
    output logic [REG_W-1:0]   rd_word
);
    localparam logic [REG_W-1:0] KEEP_MASK = {{(REG_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}};

    logic [REG_W-1:0] word_q;

    // Store the masked write word; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (wr_en)
            word_q <= wr_data & KEEP_MASK;
    end

    // Expose the stored field and the full readback word.
    always_comb begin
        field_q = word_q[FIELD_W-1:0];
        rd_word = word_q;
    end

    // R2
    field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> field_q == $past(wr_data[FIELD_W-1:0]));
    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[REG_W-1:FIELD_W] == '0);
    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(field_q));
endmodule

// File: rtl/remap_regfile.sv
// Module: the lower- and upper-bound registers with their write decode and
// read mux. Assumes a one-bit selector encoded as in remap_pkg.
module remap_regfile
    import remap_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int FIELD_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               rd_sel,
    output logic [REG_W-1:0]   rd_data,
    output logic [FIELD_W-1:0] base_f,
    output logic [FIELD_W-1:0] limit_f
);
    logic [NUM_BOUNDS-1:0]   wr_hit;
    logic [FIELD_W-1:0]      field_arr [NUM_BOUNDS];
    logic [REG_W-1:0]        word_arr  [NUM_BOUNDS];

    for (genvar g = 0; g < NUM_BOUNDS; g++) begin : g_bound
        // Route the write strobe to the selected register only.
        always_comb wr_hit[g] = wr_en && (wr_sel == 1'(g));

        remap_bound_reg #(.REG_W(REG_W), .FIELD_W(FIELD_W)) i_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_hit[g]),
            .wr_data (wr_data),
            .field_q (field_arr[g]),
            .rd_word (word_arr[g])
        );
    end

    // Pick the readback word and name the two fields.
    always_comb begin
        rd_data = (rd_sel == SEL_LIMIT) ? word_arr[SEL_LIMIT] : word_arr[SEL_BASE];
        base_f  = field_arr[SEL_BASE];
        limit_f = field_arr[SEL_LIMIT];
    end

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));
endmodule

// File: rtl/remap_range_cmp.sv
// Module: combinational window compare. It widens the lower bound with zeros
// and the upper bound with ones below the grain, then tests the address
// inclusively against both. Assumes ADDR_W > GRAIN_W.
module remap_range_cmp #(
    parameter int ADDR_W  = 36,
    parameter int GRAIN_W = 26
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [ADDR_W-GRAIN_W-1:0] base_f,
    input  logic [ADDR_W-GRAIN_W-1:0] limit_f,
    output logic                      win_en,
    output logic                      in_win,
    output logic [ADDR_W-1:0]         rel_off
);
    logic [ADDR_W-1:0] lo_edge;
    logic [ADDR_W-1:0] hi_edge;

    // Widen the bounds, enable the window, and compare.
    always_comb begin
        lo_edge = {base_f,  {GRAIN_W{1'b0}}};
        hi_edge = {limit_f, {GRAIN_W{1'b1}}};
        win_en  = (limit_f >= base_f);
        in_win  = win_en && (addr >= lo_edge) && (addr <= hi_edge);
        rel_off = addr - lo_edge;
    end
endmodule

// File: rtl/remap_window_dec.sv
// Module: top of the remap window decoder. It holds the bound registers,
// compares each qualified address, and registers the hit flag and offset.
// Assumes a synchronous active-low reset; the result lags addr by one clock.
module remap_window_dec #(
    parameter int ADDR_W  = 36,
    parameter int GRAIN_W = 26,
    parameter int REG_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_sel,
    output logic [REG_W-1:0]  rd_data,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    localparam int FIELD_W = ADDR_W - GRAIN_W;

    logic [FIELD_W-1:0] base_f;
    logic [FIELD_W-1:0] limit_f;
    logic               win_en;
    logic               in_win;
    logic [ADDR_W-1:0]  rel_off;
    logic               hit_q;
    logic [ADDR_W-1:0]  off_q;

    remap_regfile #(.REG_W(REG_W), .FIELD_W(FIELD_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .base_f  (base_f),
        .limit_f (limit_f)
    );

    remap_range_cmp #(.ADDR_W(ADDR_W), .GRAIN_W(GRAIN_W)) i_cmp (
        .addr    (addr),
        .base_f  (base_f),
        .limit_f (limit_f),
        .win_en  (win_en),
        .in_win  (in_win),
        .rel_off (rel_off)
    );

    // Register the qualified hit and the offset, zeroing the offset on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            off_q <= '0;
        end else begin
            hit_q <= addr_vld && in_win;
            off_q <= (addr_vld && in_win) ? rel_off : '0;
        end
    end

    // Drive the outputs from the result registers.
    always_comb begin
        hit    = hit_q;
        offset = off_q;
    end

    // R6
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(limit_f >= base_f));
    // R4
    upper_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(addr[ADDR_W-1:GRAIN_W] <= limit_f));
    // R5
    lower_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(addr[ADDR_W-1:GRAIN_W] >= base_f));
    // R7
    idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> !hit);
    // R8
    miss_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> offset == '0);
    // R8
    off_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> offset[GRAIN_W-1:0] == $past(addr[GRAIN_W-1:0]));
endmodule

// File: tb/test_remap_window_dec.sv
`timescale 1ns/1ps
module test_remap_window_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [15:0] rd_data;
    logic        addr_vld = 1'b0;
    logic [35:0] addr = '0;
    logic        hit;
    logic [35:0] offset;

    int checks = 0;
    int fails = 0;
    logic [9:0] m_base = '0;
    logic [9:0] m_lim = '0;

    always #2 clk = ~clk;

    remap_window_dec i_remap_window_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .addr_vld(addr_vld), .addr(addr), .hit(hit), .offset(offset)
    );

    function automatic logic exp_hit(logic [35:0] a, logic [9:0] b, logic [9:0] l);
        logic [35:0] lo = {b, 26'h0};
        logic [35:0] hi = {l, 26'h3FFFFFF};
        return (l >= b) && (a >= lo) && (a <= hi);
    endfunction

    function automatic logic [35:0] exp_off(logic [35:0] a, logic [9:0] b, logic [9:0] l);
        return exp_hit(a, b, l) ? a - {b, 26'h0} : 36'h0;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [15:0] d, input logic en);
        @(negedge clk);
        wr_en = en; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (en) begin
            if (sel) m_lim = d[9:0]; else m_base = d[9:0];
        end
    endtask

    task automatic read_check(input logic sel, input string req);
        logic [15:0] e;
        rd_sel = sel;
        #1;
        e = {6'h0, sel ? m_lim : m_base};
        check(rd_data == e, req, 64'(rd_data), 64'(e));
    endtask

    task automatic probe(input logic [35:0] a, input logic v, input string req);
        logic eh;
        logic [35:0] eo;
        @(negedge clk);
        addr = a; addr_vld = v;
        eh = v && exp_hit(a, m_base, m_lim);
        eo = v ? exp_off(a, m_base, m_lim) : 36'h0;
        @(negedge clk);
        addr_vld = 1'b0;
        check(hit == eh, req, 64'(hit), 64'(eh));
        check(offset == eo, req, 64'(offset), 64'(eo));
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(hit == 1'b0, "R1", 64'(hit), 0);
        check(offset == 36'h0, "R1", 64'(offset), 0);
        read_check(1'b0, "R1");
        read_check(1'b1, "R1");
        // R2 R3 write with reserved bits set
        write_reg(1'b0, 16'hFC05, 1'b1);
        write_reg(1'b1, 16'hA809, 1'b1);
        read_check(1'b0, "R3");
        read_check(1'b1, "R2");
        // R9 strobe low leaves registers alone
        write_reg(1'b0, 16'h03FF, 1'b0);
        write_reg(1'b1, 16'h0000, 1'b0);
        read_check(1'b0, "R9");
        read_check(1'b1, "R9");
        // R4 upper edge inclusive
        probe({10'd9, 26'h3FFFFFF}, 1'b1, "R4");
        probe({10'd10, 26'h0}, 1'b1, "R4");
        // R5 lower edge inclusive
        probe({10'd5, 26'h0}, 1'b1, "R5");
        probe({10'd4, 26'h3FFFFFF}, 1'b1, "R5");
        // R8 offset inside window
        probe({10'd7, 26'h0001234}, 1'b1, "R8");
        // R7 unqualified address gives no hit
        probe({10'd6, 26'h0}, 1'b0, "R7");
        // R6 limit below base disables
        write_reg(1'b1, 16'h0004, 1'b1);
        probe({10'd5, 26'h0}, 1'b1, "R6");
        probe({10'd4, 26'h3FFFFFF}, 1'b1, "R6");
        // R6 limit equal base gives one block
        write_reg(1'b1, 16'h0005, 1'b1);
        probe({10'd5, 26'h3FFFFFF}, 1'b1, "R6");
        probe({10'd6, 26'h0}, 1'b1, "R6");
        // R4 R5 top of address space
        write_reg(1'b0, 16'h03FF, 1'b1);
        write_reg(1'b1, 16'h03FF, 1'b1);
        probe(36'hFFFFFFFFF, 1'b1, "R4");
        probe({10'h3FF, 26'h0}, 1'b1, "R5");
        // R4 R5 R6 R7 R8 random windows and addresses
        for (int i = 0; i < 300; i++) begin
            logic [9:0] fb = 10'($urandom % 16);
            logic [9:0] fl = 10'($urandom % 16);
            logic [9:0] fa = 10'($urandom % 18);
            logic [25:0] lo;
            case ($urandom % 3)
                0: lo = 26'h0;
                1: lo = 26'h3FFFFFF;
                default: lo = 26'($urandom);
            endcase
            if (i % 10 == 0) begin
                write_reg(1'b0, 16'($urandom) & 16'hFC00 | {6'h0, fb}, 1'b1);
                write_reg(1'b1, {6'h0, fl}, 1'b1);
            end
            probe({fa, lo}, ($urandom % 5) != 0, "R8");
        end
        // R1 reset mid-run clears everything
        @(negedge clk);
        addr = {m_base, 26'h0}; addr_vld = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; addr_vld = 1'b0;
        m_base = '0; m_lim = '0;
        check(hit == 1'b0, "R1", 64'(hit), 0);
        read_check(1'b0, "R1");
        read_check(1'b1, "R1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule